// File: doc/BRIEF.md
# PWM Leading-Edge Blanking Unit

This block keeps switching transients from being read as faults. It watches both outputs of a complementary PWM pair (high side and low side). When one of the edges selected in its control register occurs, it opens a blanking window of programmable length. While the window is open, the fault sense input, the current-limit sense input, or both are held at their inactive level before they reach the protection logic downstream. Outside the window, both sense inputs pass through unchanged.

A single 16-bit control register holds all the settings. Four bits select the edges that trigger blanking. Two bits choose which sense paths are masked. A 7-bit field sets the duration, counted in steps of eight clock cycles. Any enabled edge restarts one shared timer. An edge that arrives while a window is open therefore extends blanking from that newest edge.

Top module: `pwm_blanking_unit`

## Requirements
- R1: After reset, cfg_rdata reads 0x0000, blank_active is 0, and both masked outputs equal their raw inputs.
- R2: A write with cfg_we loads cfg_wdata[15:3] into the register. From the next cycle, cfg_rdata returns that value with bits 2:0 always reading 0.
- R3: The edge-enable bits are: bit 15 for the high-side rise, bit 14 for the high-side fall, bit 13 for the low-side rise and bit 12 for the low-side fall. Each one on its own makes its edge start blanking.
- R4: An edge whose enable bit is 0 does not start blanking.
- R5: Let D be the value of bits 9:3. An enabled edge with D nonzero makes blank_active high during the cycle in which the edge is seen and for D*8-1 further cycles, which is D*8 cycles in total.
- R6: An enabled edge that occurs while blanking is active reloads the timer. The window then ends D*8 cycles after the cycle of the newest edge.
- R7: When D is 0, an enabled edge produces no blanking cycle.
- R8: With bit 11 set, flt_out is 0 while blank_active is high. With bit 11 clear, flt_out always equals flt_in.
- R9: With bit 10 set, ilim_out is 0 while blank_active is high. With bit 10 clear, ilim_out always equals ilim_in.
- R10: Rewriting the duration while a window is open leaves that window's end unchanged.
- R11: Outside a blanking window, flt_out and ilim_out follow flt_in and ilim_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| pwm_hi | input | 1 | High-side PWM output |
| pwm_lo | input | 1 | Low-side PWM output |
| flt_in | input | 1 | Raw fault sense, active high |
| ilim_in | input | 1 | Raw current-limit sense, active high |
| flt_out | output | 1 | Blanked fault sense |
| ilim_out | output | 1 | Blanked current-limit sense |
| blank_active | output | 1 | High while the blanking window is open |

## Verification
Two functions can fall in the same cycle: a new enabled edge and the last cycle of a running window. The bench provokes this by applying a second edge exactly in the final blanking cycle, with the fault input held high. It passes only if blanking and the fault mask carry on without a one-cycle gap and the window then closes D*8 cycles after that second edge. In a second overlap case, the duration field is rewritten in the middle of a window, and the old end time must still hold.

// File: rtl/pwm_blanking_unit.sv
module pwm_blanking_unit #(
  parameter int STEP_SH = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        pwm_hi,
  input  logic        pwm_lo,
  input  logic        flt_in,
  input  logic        ilim_in,
  output logic        flt_out,
  output logic        ilim_out,
  output logic        blank_active
);
  localparam int DUR_W = 7;
  localparam int CNT_W = DUR_W + STEP_SH;

  logic [12:0]      cfg_q;
  logic             hi_q, lo_q;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       edges;
  logic [DUR_W-1:0] dur;
  logic             fire;
  logic [CNT_W-1:0] load_val;

  assign dur      = cfg_q[6:0];
  assign edges    = {pwm_hi & ~hi_q, ~pwm_hi & hi_q, pwm_lo & ~lo_q, ~pwm_lo & lo_q};
  assign fire     = (|(edges & cfg_q[12:9])) && (dur != '0);
  assign load_val = (CNT_W'(dur) << STEP_SH) - CNT_W'(1);

  assign blank_active = fire || (cnt != '0);
  assign flt_out      = flt_in  & ~(blank_active & cfg_q[8]);
  assign ilim_out     = ilim_in & ~(blank_active & cfg_q[7]);
  assign cfg_rdata    = {cfg_q, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata[15:3];
      hi_q <= pwm_hi;
      lo_q <= pwm_lo;
      if (fire)             cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end
  end

  p_write_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == {$past(cfg_wdata[15:3]), 3'b000});

  p_start_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> blank_active);

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !fire) |=> cnt == $past(cnt) - CNT_W'(1));

  p_pass_flt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_active |-> (flt_out == flt_in && ilim_out == ilim_in));

  p_zero_dur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[9:3] == 7'd0 && cnt == '0) |=> cnt == '0);
endmodule

// File: tb/pwm_blanking_unit_tb.sv
`timescale 1ns/1ps
module pwm_blanking_unit_tb;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic pwm_hi = 0, pwm_lo = 0, flt_in = 0, ilim_in = 0;
  logic flt_out, ilim_out, blank_active;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  pwm_blanking_unit u_dut (.clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata,
    .pwm_hi, .pwm_lo, .flt_in, .ilim_in, .flt_out, .ilim_out, .blank_active);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [15:0] v);
    tick(); cfg_we = 1; cfg_wdata = v;
    tick(); cfg_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // call right after the edge-applying tick; checks n blanking cycles then clear
  task automatic win(input string tag, input int n);
    #1 chk(tag, blank_active, 1);
    for (int k = 1; k < n; k++) begin tick(); #1 chk(tag, blank_active, 1); end
    tick(); #1 chk(tag, blank_active, 0);
  endtask

  task automatic t_reset();
    #1 chk("R1 rdata", cfg_rdata, 16'h0000);
    chk("R1 blank", blank_active, 0);
    flt_in = 1; ilim_in = 1; #1;
    chk("R1 flt", flt_out, 1); chk("R1 ilim", ilim_out, 1);
    flt_in = 0; ilim_in = 0;
  endtask

  task automatic t_write();
    wr(16'hFFFF); #1 chk("R2 readback", cfg_rdata, 16'hFFF8);
    wr(16'h0000); #1 chk("R2 clear", cfg_rdata, 16'h0000);
  endtask

  task automatic t_each_edge();
    wr(16'h8008); tick(); pwm_hi = 1; win("R3 hi rise", 8); idle(2);
    wr(16'h4008); tick(); pwm_hi = 0; win("R3 hi fall", 8); idle(2);
    wr(16'h2008); tick(); pwm_lo = 1; win("R3 lo rise", 8); idle(2);
    wr(16'h1008); tick(); pwm_lo = 0; win("R3 lo fall", 8); idle(2);
  endtask

  task automatic t_disabled();
    wr(16'h7010);
    tick(); pwm_hi = 1; #1 chk("R4 hi rise off", blank_active, 0);
    tick(); #1 chk("R4 still off", blank_active, 0);
    wr(16'hB010); tick(); pwm_hi = 0; #1 chk("R4 hi fall off", blank_active, 0);
    tick(); pwm_hi = 1; win("R5 D=2 window", 16); idle(2);
    tick(); pwm_hi = 0; idle(2);
  endtask

  task automatic t_zero();
    wr(16'hF000);
    tick(); pwm_lo = 1; #1 chk("R7 zero dur", blank_active, 0);
    tick(); #1 chk("R7 zero dur after", blank_active, 0);
    tick(); pwm_lo = 0; idle(2);
  endtask

  task automatic t_masks();
    flt_in = 1; ilim_in = 1;
    wr(16'h8808); tick(); pwm_hi = 1; #1;
    chk("R8 flt masked", flt_out, 0); chk("R9 ilim unmasked", ilim_out, 1);
    idle(8); #1 chk("R11 flt back", flt_out, 1);
    tick(); pwm_hi = 0;
    wr(16'h4408); tick(); pwm_hi = 1; tick(); pwm_hi = 0; #1;
    chk("R9 ilim masked", ilim_out, 0); chk("R8 flt unmasked", flt_out, 1);
    idle(8); #1 chk("R11 ilim back", ilim_out, 1);
    flt_in = 0; ilim_in = 0; idle(2);
  endtask

  task automatic t_retrigger();
    // second edge on the final blanking cycle of the first window, fault held high
    wr(16'hC808); flt_in = 1;
    tick(); pwm_hi = 1; #1 chk("R6 first", blank_active, 1);
    for (int k = 1; k < 7; k++) begin tick(); #1 chk("R6 first run", blank_active, 1); end
    tick(); pwm_hi = 0; #1 chk("R6 overlap flt", flt_out, 0);
    win("R6 extended", 8);
    chk("R11 flt after", flt_out, 1);
    flt_in = 0; idle(2);
  endtask

  task automatic t_dur_change();
    wr(16'h8010); tick(); pwm_hi = 1; #1 chk("R10 start", blank_active, 1);
    tick(); cfg_we = 1; cfg_wdata = 16'h83F8; tick(); cfg_we = 0;
    for (int k = 3; k < 16; k++) begin tick(); #1 chk("R10 keep", blank_active, 1); end
    tick(); #1 chk("R10 end", blank_active, 0);
    tick(); pwm_hi = 0; idle(2);
  endtask

  initial begin
    #500000;
    nfail++;
    $display("FAIL watchdog got timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    idle(2); rst_n = 1; idle(1);
    t_write();
    t_each_edge();
    t_disabled();
    t_zero();
    t_masks();
    t_retrigger();
    t_dur_change();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule